// File: doc/BRIEF.md
# Event Interrupt, Halt and Reset Controller

This block collects event pulses from two serial-bus master engines, each with two command queues, into one 32-bit interrupt status word. Software reads the status, writes the same bits back to clear them, and then writes a global clear command. That command lets the single level interrupt output fall. A mask register selects which status bits may raise the interrupt.

The block also sequences engine halts and soft resets. A halt request stops both queues of one master. A reset command carries a bit mask that selects which parts of the controller are held in reset. Each sequence completes after a fixed latency and reports completion as a status bit.

Errors reported by a master's queues start a halt of that master on their own. When that halt, or any other halt, is acknowledged, the block starts a reset limited to the halted master. The bus engines are outside the block. Here they appear only as event inputs and as the halt and reset outputs.

Top module: `ctl_irq_unit`

## Requirements
- R1: After reset, `statusOut`, `irqOut`, `haltOut` and `rstMaskOut` are all zero.
- R2: An event pulse sampled at a clock edge sets its status bit at that edge. `engEvt[i]` maps to status bit i for i in 0..23, and `nackEvt[n]` maps to status bit 27+n. Status bits 3, 15 and 31 never become set.
- R3: A write to register select 1 clears every status bit whose data bit is 1 and keeps all other bits. If an event sets a bit in the same cycle as a clear of that bit, the bit stays set.
- R4: A write to register select 0 loads the mask. `irqOut` rises one clock after the AND of status and mask becomes nonzero. Status bits whose mask bit is 0 never raise `irqOut`.
- R5: Once high, `irqOut` stays high, even after its status bits are cleared, until a write to register select 2 with data bit 0 equal to 1. At that edge it takes the value of the OR over status AND mask. A write to select 2 with data bit 0 equal to 0 has no effect.
- R6: A write to register select 3 with data bit m set, for m in 0..1, while master m is not halting, drives `haltOut[m]` high for exactly 8 cycles. Status bit 25+m sets at the edge where `haltOut[m]` falls. A new halt request for master m while it is halting does not extend the halt.
- R7: A write to register select 4 with nonzero data drives `rstMaskOut` to that data for 8 cycles and then back to 0. Status bit 24 sets at the edge where it returns to 0. A request while a reset is running ORs its mask in and restarts the 8-cycle count. Writing zero data does nothing.
- R8: Any event in master 0's error group (status mask 0x18000ee6) or master 1's error group (status mask 0x60ee6000) starts a halt of that master at the same edge, unless that master is already halting.
- R9: At the edge where the halt of master m completes, a reset starts with mask 0x000003f1 for master 0 or 0x0003f001 for master 1. This mask is merged with any other reset request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select: 0 mask, 1 clear, 2 global clear, 3 halt, 4 reset |
| wrData | input | 32 | Write data |
| engEvt | input | 24 | Engine event pulses, 12 per master, mapped to status bits 0..23 |
| nackEvt | input | 4 | Queue NACK pulses, index = master*2 + queue |
| statusOut | output | 32 | Interrupt status word |
| irqOut | output | 1 | Level interrupt |
| haltOut | output | 2 | Per-master halt in progress |
| rstMaskOut | output | 32 | Active reset mask, zero when idle |

## Verification
The bench sweeps every event input one at a time. For each one it checks the single status bit it sets and whether it halts its master, so a wrong bit map or an error group with a missing or extra bit shows up as a wrong status word or a stray halt. It also targets the clear that coincides with a new event, since a design that lets the clear win would lose that event. The interrupt is checked as it is held through a clear and released only by the global clear with bit 0 set, so an output that follows the status directly falls too early. Halt and reset lengths are counted cycle by cycle, including a repeated halt that must not extend the window and a merged reset that must restart it. Off-by-one latency and dropped merge masks therefore give a wrong count or mask.

// File: rtl/ctl_irq_pkg.sv
package ctl_irq_pkg;

  localparam int NUM_MASTERS   = 2;
  localparam int NUM_QUEUES    = 2;
  localparam int EVT_PER_MSTR  = 12;
  localparam int ENG_EVT_W     = NUM_MASTERS * EVT_PER_MSTR;
  localparam int NACK_W        = NUM_MASTERS * NUM_QUEUES;
  localparam int STAT_W        = 32;
  localparam int RST_ACK_BIT   = 24;
  localparam int HALT_ACK_BASE = 25;
  localparam int NACK_BASE     = 27;

  // bits 3, 15 and 31 are reserved and never set
  localparam logic [STAT_W-1:0] VALID_BITS = 32'h7fff7ff7;

  typedef enum logic [2:0] {
    SEL_MASK   = 3'd0,
    SEL_CLEAR  = 3'd1,
    SEL_GCLEAR = 3'd2,
    SEL_HALT   = 3'd3,
    SEL_RESET  = 3'd4
  } regSel_e;

  typedef struct packed {
    logic                   maskWr;
    logic                   clearWr;
    logic                   globalClr;
    logic                   rstAck;
    logic [NUM_MASTERS-1:0] haltAck;
    logic [STAT_W-1:0]      data;
  } ctlStrobe_t;

  function automatic logic [STAT_W-1:0] errGroup(input int m);
    return (m == 0) ? 32'h18000ee6 : 32'h60ee6000;
  endfunction

  function automatic logic [STAT_W-1:0] masterRstMask(input int m);
    return (m == 0) ? 32'h000003f1 : 32'h0003f001;
  endfunction

endpackage

// File: rtl/ctl_irq_ctrl.sv
module ctl_irq_ctrl
  import ctl_irq_pkg::*;
#(
  parameter int ACK_LAT = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wrEn,
  input  logic [2:0]             wrAddr,
  input  logic [STAT_W-1:0]      wrData,
  input  logic [NUM_MASTERS-1:0] errHit,
  output ctlStrobe_t             strobe,
  output logic [NUM_MASTERS-1:0] haltOut,
  output logic [STAT_W-1:0]      rstMaskOut
);

  localparam int LAT_W = $clog2(ACK_LAT + 1);
  localparam logic [LAT_W-1:0] LAT_LOAD = LAT_W'(ACK_LAT);
  localparam logic [LAT_W-1:0] LAT_ONE  = LAT_W'(1);

  regSel_e sel;
  logic    selHit;
  logic [NUM_MASTERS-1:0] haltDone;

  assign sel    = regSel_e'(wrAddr);
  assign selHit = wrEn;

  // per-master halt sequencers
  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_halt
    logic [LAT_W-1:0] haltCnt;
    logic             haltReq;

    assign haltReq = (selHit && sel == SEL_HALT && wrData[m]) || errHit[m];

    always_ff @(posedge clk) begin
      if (rst) begin
        haltCnt <= '0;
      end else if (haltCnt == '0) begin
        if (haltReq) haltCnt <= LAT_LOAD;
      end else begin
        haltCnt <= haltCnt - LAT_ONE;
      end
    end

    assign haltDone[m] = (haltCnt == LAT_ONE);
    assign haltOut[m]  = (haltCnt != '0);
  end

  // reset sequencer: software mask merged with per-master masks after halt
  logic [STAT_W-1:0] autoMask;
  logic [STAT_W-1:0] reqMask;
  logic              rstReq;
  logic [LAT_W-1:0]  rstCnt;
  logic [STAT_W-1:0] rstMaskQ;

  always_comb begin
    autoMask = '0;
    for (int m = 0; m < NUM_MASTERS; m++) begin
      if (haltDone[m]) autoMask = autoMask | masterRstMask(m);
    end
    reqMask = autoMask;
    if (selHit && sel == SEL_RESET) reqMask = reqMask | wrData;
    rstReq = (reqMask != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rstCnt   <= '0;
      rstMaskQ <= '0;
    end else if (rstReq) begin
      rstCnt   <= LAT_LOAD;
      rstMaskQ <= rstMaskQ | reqMask;
    end else if (rstCnt != '0) begin
      rstCnt <= rstCnt - LAT_ONE;
      if (rstCnt == LAT_ONE) rstMaskQ <= '0;
    end
  end

  assign rstMaskOut = rstMaskQ;

  always_comb begin
    strobe.maskWr    = selHit && sel == SEL_MASK;
    strobe.clearWr   = selHit && sel == SEL_CLEAR;
    strobe.globalClr = selHit && sel == SEL_GCLEAR && wrData[0];
    strobe.rstAck    = (rstCnt == LAT_ONE) && !rstReq;
    strobe.haltAck   = haltDone;
    strobe.data      = wrData;
  end

endmodule

// File: rtl/ctl_irq_datapath.sv
module ctl_irq_datapath
  import ctl_irq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  ctlStrobe_t             strobe,
  input  logic [ENG_EVT_W-1:0]   engEvt,
  input  logic [NACK_W-1:0]      nackEvt,
  output logic [STAT_W-1:0]      statusQ,
  output logic                   irqQ,
  output logic [NUM_MASTERS-1:0] errHit
);

  logic [STAT_W-1:0] evtBits;
  logic [STAT_W-1:0] ackBits;
  logic [STAT_W-1:0] clrBits;
  logic [STAT_W-1:0] maskQ;
  logic              pending;

  always_comb begin
    evtBits = '0;
    evtBits[ENG_EVT_W-1:0] = engEvt;
    evtBits[NACK_BASE +: NACK_W] = nackEvt;
    evtBits = evtBits & VALID_BITS;

    ackBits = '0;
    ackBits[RST_ACK_BIT] = strobe.rstAck;
    ackBits[HALT_ACK_BASE +: NUM_MASTERS] = strobe.haltAck;

    clrBits = strobe.clearWr ? strobe.data : '0;
  end

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_err
    assign errHit[m] = |(evtBits & errGroup(m));
  end

  assign pending = |(statusQ & maskQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      statusQ <= '0;
      maskQ   <= '0;
      irqQ    <= 1'b0;
    end else begin
      // new events win over a simultaneous clear
      statusQ <= ((statusQ & ~clrBits) | evtBits | ackBits) & VALID_BITS;
      if (strobe.maskWr) maskQ <= strobe.data & VALID_BITS;
      if (!irqQ)                 irqQ <= pending;
      else if (strobe.globalClr) irqQ <= pending;
    end
  end

endmodule

// File: rtl/ctl_irq_unit.sv
module ctl_irq_unit
  import ctl_irq_pkg::*;
#(
  parameter int ACK_LAT = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [23:0] engEvt,
  input  logic [3:0]  nackEvt,
  output logic [31:0] statusOut,
  output logic        irqOut,
  output logic [1:0]  haltOut,
  output logic [31:0] rstMaskOut
);

  ctlStrobe_t             strobe;
  logic [NUM_MASTERS-1:0] errHit;

  ctl_irq_ctrl #(.ACK_LAT(ACK_LAT)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .errHit     (errHit),
    .strobe     (strobe),
    .haltOut    (haltOut),
    .rstMaskOut (rstMaskOut)
  );

  ctl_irq_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .engEvt  (engEvt),
    .nackEvt (nackEvt),
    .statusQ (statusOut),
    .irqQ    (irqOut),
    .errHit  (errHit)
  );

endmodule

// File: rtl/ctl_irq_checker.sv
module ctl_irq_checker (
  input logic        clk,
  input logic        rst,
  input logic        gClrHit,
  input logic        clrBit0,
  input logic        evtBit0,
  input logic [1:0]  errM,
  input logic [31:0] statusOut,
  input logic        irqOut,
  input logic [1:0]  haltOut,
  input logic [31:0] rstMaskOut
);

  p_event_sets_r2: assert property (@(posedge clk) disable iff (rst)
    evtBit0 |=> statusOut[0]);

  p_set_beats_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (evtBit0 && clrBit0) |=> statusOut[0]);

  p_irq_has_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(irqOut) |-> $past(statusOut != 32'h0));

  p_irq_held_r5: assert property (@(posedge clk) disable iff (rst)
    (irqOut && !gClrHit) |=> irqOut);

  p_halt_ack0_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(haltOut[0]) |-> statusOut[25]);

  p_halt_ack1_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(haltOut[1]) |-> statusOut[26]);

  p_rst_ack_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(rstMaskOut != 32'h0) |-> statusOut[24]);

  p_err_halt0_r8: assert property (@(posedge clk) disable iff (rst)
    (errM[0] && !haltOut[0]) |=> haltOut[0]);

  p_err_halt1_r8: assert property (@(posedge clk) disable iff (rst)
    (errM[1] && !haltOut[1]) |=> haltOut[1]);

  p_halt_reset0_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(haltOut[0]) |-> ((rstMaskOut & 32'h000003f1) == 32'h000003f1));

  p_halt_reset1_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(haltOut[1]) |-> ((rstMaskOut & 32'h0003f001) == 32'h0003f001));

endmodule

bind ctl_irq_unit ctl_irq_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .gClrHit    (wrEn && wrAddr == 3'd2 && wrData[0]),
  .clrBit0    (wrEn && wrAddr == 3'd1 && wrData[0]),
  .evtBit0    (engEvt[0]),
  .errM       ({(|(engEvt[23:12] & 12'hee6)) || (|nackEvt[3:2]),
                (|(engEvt[11:0]  & 12'hee6)) || (|nackEvt[1:0])}),
  .statusOut  (statusOut),
  .irqOut     (irqOut),
  .haltOut    (haltOut),
  .rstMaskOut (rstMaskOut)
);

// File: tb/ctl_irq_unit_bench.sv
module ctl_irq_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VALID = 32'h7fff7ff7;
  localparam logic [31:0] ERR0  = 32'h18000ee6;
  localparam logic [31:0] ERR1  = 32'h60ee6000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [23:0] engEvt = '0;
  logic [3:0]  nackEvt = '0;
  logic [31:0] statusOut;
  logic        irqOut;
  logic [1:0]  haltOut;
  logic [31:0] rstMaskOut;

  int checks = 0;
  int errors = 0;
  int h0 = 0;
  int h1 = 0;
  int rc = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ctl_irq_unit u_ctl_irq_unit (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .engEvt(engEvt), .nackEvt(nackEvt), .statusOut(statusOut),
    .irqOut(irqOut), .haltOut(haltOut), .rstMaskOut(rstMaskOut)
  );

  always @(posedge clk) begin
    if (haltOut[0]) h0 <= h0 + 1;
    if (haltOut[1]) h1 <= h1 + 1;
    if (rstMaskOut != 0) rc <= rc + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulseEng(input logic [23:0] v);
    engEvt = v;
    @(negedge clk);
    engEvt = '0;
  endtask

  task automatic pulseNack(input logic [3:0] v);
    nackEvt = v;
    @(negedge clk);
    nackEvt = '0;
  endtask

  task automatic drain();
    tick(20);
    wr(3'd1, 32'hffffffff);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 status", statusOut, 32'h0);
    chk("R1 irq", {31'h0, irqOut}, 32'h0);
    chk("R1 halt", {30'h0, haltOut}, 32'h0);
    chk("R1 rstMask", rstMaskOut, 32'h0);

    // R2 / R8: sweep every engine event input
    for (int i = 0; i < 24; i++) begin
      logic [31:0] bitv;
      logic [31:0] grp;
      logic [1:0]  expHalt;
      bitv = 32'h1 << i;
      grp  = (i < 12) ? ERR0 : ERR1;
      expHalt = ((grp & bitv) != 0) ? ((i < 12) ? 2'b01 : 2'b10) : 2'b00;
      pulseEng(24'h1 << i);
      chk("R2 engine event bit", statusOut, bitv & VALID);
      chk("R8 error halt", {30'h0, haltOut}, {30'h0, expHalt});
      drain();
      chk("R3 clear all", statusOut, 32'h0);
    end
    for (int n = 0; n < 4; n++) begin
      pulseNack(4'h1 << n);
      chk("R2 nack event bit", statusOut, 32'h1 << (27 + n));
      chk("R8 nack halt", {30'h0, haltOut}, (n < 2) ? 32'h1 : 32'h2);
      drain();
    end

    // R3 clear and set-wins
    pulseEng(24'h011);
    chk("R3 setup", statusOut, 32'h11);
    wr(3'd1, 32'h1);
    chk("R3 partial clear", statusOut, 32'h10);
    engEvt = 24'h1; wrEn = 1'b1; wrAddr = 3'd1; wrData = 32'h11;
    @(negedge clk);
    engEvt = '0; wrEn = 1'b0; wrData = '0;
    chk("R3 event beats clear", statusOut, 32'h1);

    // R4 / R5 interrupt
    wr(3'd0, 32'h1);
    chk("R4 irq not yet", {31'h0, irqOut}, 32'h0);
    tick(1);
    chk("R4 irq rises", {31'h0, irqOut}, 32'h1);
    wr(3'd1, 32'h1);
    chk("R5 status cleared", statusOut, 32'h0);
    chk("R5 irq held", {31'h0, irqOut}, 32'h1);
    tick(2);
    wr(3'd2, 32'h0);
    chk("R5 gclear bit0 zero", {31'h0, irqOut}, 32'h1);
    wr(3'd2, 32'h1);
    chk("R5 gclear releases", {31'h0, irqOut}, 32'h0);
    pulseEng(24'h10);
    tick(3);
    chk("R4 masked bit", {31'h0, irqOut}, 32'h0);
    pulseEng(24'h1);
    chk("R4 event irq delay", {31'h0, irqOut}, 32'h0);
    tick(1);
    chk("R4 event irq rise", {31'h0, irqOut}, 32'h1);
    wr(3'd1, 32'hffffffff);
    wr(3'd2, 32'h1);
    chk("R5 final release", {31'h0, irqOut}, 32'h0);
    wr(3'd0, 32'h0);

    // R6 / R9 halt master 0
    h0 = 0;
    wr(3'd3, 32'h1);
    chk("R6 halt starts", {30'h0, haltOut}, 32'h1);
    tick(7);
    chk("R6 halt still", {30'h0, haltOut}, 32'h1);
    chk("R6 no ack yet", statusOut, 32'h0);
    tick(1);
    chk("R6 halt ends", {30'h0, haltOut}, 32'h0);
    chk("R6 halt ack", statusOut, 32'h1 << 25);
    chk("R6 halt length", h0, 32'd8);
    chk("R9 master0 reset", rstMaskOut, 32'h000003f1);
    tick(7);
    chk("R9 reset held", rstMaskOut, 32'h000003f1);
    tick(1);
    chk("R7 reset ends", rstMaskOut, 32'h0);
    chk("R7 reset ack", statusOut, (32'h1 << 25) | (32'h1 << 24));
    wr(3'd1, 32'hffffffff);

    // R6 repeated request does not extend
    h1 = 0;
    wr(3'd3, 32'h2);
    tick(2);
    wr(3'd3, 32'h2);
    tick(10);
    chk("R6 repeat ignored", h1, 32'd8);
    chk("R9 master1 reset", rstMaskOut, 32'h0003f001);
    drain();

    // R9 both halts together
    wr(3'd3, 32'h3);
    tick(7);
    tick(1);
    chk("R9 both masks", rstMaskOut, 32'h0003f3f1);
    chk("R6 both acks", statusOut, 32'h06000000);
    drain();

    // R7 software reset
    rc = 0;
    wr(3'd4, 32'h0f73f3f7);
    chk("R7 full mask", rstMaskOut, 32'h0f73f3f7);
    tick(8);
    chk("R7 length", rc, 32'd8);
    chk("R7 done ack", statusOut, 32'h1 << 24);
    chk("R7 idle mask", rstMaskOut, 32'h0);
    wr(3'd1, 32'hffffffff);
    wr(3'd4, 32'h0);
    chk("R7 zero ignored", rstMaskOut, 32'h0);
    tick(9);
    chk("R7 zero no ack", statusOut, 32'h0);
    rc = 0;
    wr(3'd4, 32'h1);
    tick(2);
    wr(3'd4, 32'h100);
    chk("R7 merged mask", rstMaskOut, 32'h101);
    tick(8);
    chk("R7 restart length", rc, 32'd11);
    chk("R7 merged ack", statusOut, 32'h1 << 24);
    wr(3'd1, 32'hffffffff);

    // R8 / R9 error path on master 1
    pulseNack(4'h4);
    tick(8);
    chk("R8 error halt ack", statusOut, (32'h1 << 29) | (32'h1 << 26));
    chk("R9 error reset", rstMaskOut, 32'h0003f001);
    drain();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule